// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block gives software control of 174 general-purpose pins split into six banks. Banks 0 to 2 carry 26 pins each and banks 3 to 5 carry 32 pins each. A plain 32-bit register bus reaches every bank. Through it, software can do the following:

- replace a bank's output levels,
- read back the synchronized pin levels,
- set the per-pin direction and output-enable bits,
- adjust a per-bank interrupt mask through separate set and clear registers.

Each bank also has two half-word masked write registers. The low one covers pins 0 to 15 and the high one covers pins 16 to 31. In a masked-write word, the upper 16 bits are an active-low per-bit mask and the lower 16 bits are the new levels. One store therefore changes only the chosen pins, with no read-modify-write. This lets independent software agents share a bank without locking.

A pin drives its pad only when both its direction bit and its output-enable bit are set. Pin inputs pass through two flip-flops before the input register can see them.

Top module: `gpio_multibank`

## Requirements
- R1: After reset, every bank's output, direction and output-enable registers read 0, and the interrupt mask reads all ones over the bank's implemented pins. `pin_out` and `pin_oe` are all 0.
- R2: A write to offset 8×bank (low masked write) works per bit for bank pins 0 to 15. Bit i of the pin takes wdata[i] where wdata[16+i] is 0. It keeps its level where wdata[16+i] is 1.
- R3: A write to offset 8×bank+4 (high masked write) applies the same active-low mask rule to bank pins 16 to 31. wdata[i] and wdata[16+i] govern pin 16+i.
- R4: A write to offset 0x40+4×bank replaces every output bit of the bank. A read there returns the output bits. `pin_out` for the bank equals this register.
- R5: A read at offset 0x60+4×bank returns the bank's pin input levels. A level changed between two clock edges first appears in a read sampled at the third following edge. Reads at the first two edges return the old level.
- R6: The direction register is at 0x204+0x40×bank (1 = output) and the output-enable register is at 0x208+0x40×bank (1 = enabled). Both read back as written. One cycle after they update, `pin_oe` for each pin equals the AND of its two bits.
- R7: Writing 1s to offset 0x210+0x40×bank clears the matching interrupt mask bits. Writing 1s to 0x214+0x40×bank sets them. Zero bits written have no effect. The mask reads at 0x20C+0x40×bank and ignores writes.
- R8: Register bits above a bank's pin count read 0 and ignore writes. Unmapped offsets read 0. The masked-write, interrupt-enable and interrupt-disable registers read 0.
- R9: `bus_rdata` is loaded on the clock edge that samples `bus_rd` high. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 174 | Pin input levels, flat across banks |
| pin_out | output | 174 | Pin output levels |
| pin_oe | output | 174 | Pin driver enables |

## Verification
Register writes take effect at the edge that samples `bus_wr`. A read issued one cycle later returns the new value. `pin_out` follows in the same edge as the register write. `pin_oe` lags the control registers by one more edge. An input change crosses two flops, so the bench holds the read strobe across three edges and requires old, old, new.

The bench drives every strobe on the falling edge and samples after the rising edge that consumes it. For `pin_oe`, it waits one extra falling edge before comparing, so each comparison lands exactly in the cycle where the result is due.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned MSK_STRIDE = 8;
  localparam int unsigned DAT_STRIDE = 4;
  localparam int unsigned CTL_STRIDE = 64;
  localparam int unsigned DOUT_BASE  = 'h040;
  localparam int unsigned DIN_BASE   = 'h060;
  localparam int unsigned CTL_BASE   = 'h200;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MLO, SEL_MHI, SEL_DOUT, SEL_DIN,
    SEL_DIR, SEL_OEN, SEL_IMASK, SEL_IEN, SEL_IDIS
  } reg_sel_e;

  function automatic int unsigned bank_pins(int unsigned b, int unsigned nb,
                                            int unsigned np, int unsigned wp);
    return (b < nb) ? np : wp;
  endfunction

  function automatic int unsigned bank_base(int unsigned b, int unsigned nb,
                                            int unsigned np, int unsigned wp);
    return (b <= nb) ? b * np : nb * np + (b - nb) * wp;
  endfunction
endpackage

// File: rtl/gpio_mb_decode.sv
module gpio_mb_decode
  import gpio_mb_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_MLO   = ADDR_W'(MSK_STRIDE * BANK_IDX);
  localparam logic [ADDR_W-1:0] A_MHI   = ADDR_W'(MSK_STRIDE * BANK_IDX + 4);
  localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(DOUT_BASE + DAT_STRIDE * BANK_IDX);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(DIN_BASE + DAT_STRIDE * BANK_IDX);
  localparam int unsigned       CTL     = CTL_BASE + CTL_STRIDE * BANK_IDX;
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(CTL + 'h04);
  localparam logic [ADDR_W-1:0] A_OEN   = ADDR_W'(CTL + 'h08);
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(CTL + 'h0C);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(CTL + 'h10);
  localparam logic [ADDR_W-1:0] A_IDIS  = ADDR_W'(CTL + 'h14);

  always_comb begin
    if      (addr == A_MLO)   sel = SEL_MLO;
    else if (addr == A_MHI)   sel = SEL_MHI;
    else if (addr == A_DOUT)  sel = SEL_DOUT;
    else if (addr == A_DIN)   sel = SEL_DIN;
    else if (addr == A_DIR)   sel = SEL_DIR;
    else if (addr == A_OEN)   sel = SEL_OEN;
    else if (addr == A_IMASK) sel = SEL_IMASK;
    else if (addr == A_IEN)   sel = SEL_IEN;
    else if (addr == A_IDIS)  sel = SEL_IDIS;
    else                      sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
  import gpio_mb_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned PINS     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [DATA_W-1:0] rdata,
  output logic              hit,
  output logic [PINS-1:0]   dout,
  output logic [PINS-1:0]   oe
);
  localparam int unsigned HI_W = PINS - HALF_W;

  reg_sel_e        sel;
  logic [PINS-1:0] dout_q, dir_q, oen_q, imask_q, oe_q, din_s;
  logic            wr_mlo, wr_mhi, wr_dout, wr_dir, wr_oen, wr_ien, wr_idis;

  gpio_mb_decode #(.BANK_IDX(BANK_IDX)) u_dec (.addr(addr), .sel(sel));

  gpio_mb_sync #(.W(PINS)) u_sync (.clk(clk), .rst(rst), .d(pin_in), .q(din_s));

  assign wr_mlo  = wr_en && (sel == SEL_MLO);
  assign wr_mhi  = wr_en && (sel == SEL_MHI);
  assign wr_dout = wr_en && (sel == SEL_DOUT);
  assign wr_dir  = wr_en && (sel == SEL_DIR);
  assign wr_oen  = wr_en && (sel == SEL_OEN);
  assign wr_ien  = wr_en && (sel == SEL_IEN);
  assign wr_idis = wr_en && (sel == SEL_IDIS);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dir_q   <= '0;
      oen_q   <= '0;
      imask_q <= '1;
      oe_q    <= '0;
    end else begin
      oe_q <= dir_q & oen_q;
      if (wr_dout) begin
        dout_q <= wdata[PINS-1:0];
      end else if (wr_mlo) begin
        for (int i = 0; i < HALF_W; i++)
          if (!wdata[HALF_W+i]) dout_q[i] <= wdata[i];
      end else if (wr_mhi) begin
        for (int i = 0; i < HI_W; i++)
          if (!wdata[HALF_W+i]) dout_q[HALF_W+i] <= wdata[i];
      end
      if (wr_dir) dir_q <= wdata[PINS-1:0];
      if (wr_oen) oen_q <= wdata[PINS-1:0];
      if (wr_ien)
        imask_q <= imask_q & ~wdata[PINS-1:0];
      else if (wr_idis)
        imask_q <= imask_q | wdata[PINS-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DOUT:  rdata = DATA_W'(dout_q);
      SEL_DIN:   rdata = DATA_W'(din_s);
      SEL_DIR:   rdata = DATA_W'(dir_q);
      SEL_OEN:   rdata = DATA_W'(oen_q);
      SEL_IMASK: rdata = DATA_W'(imask_q);
      default:   rdata = '0;
    endcase
  end

  assign hit  = (sel != SEL_NONE);
  assign dout = dout_q;
  assign oe   = oe_q;

  // R2: masked bits keep level, unmasked bits load data
  assert_mlo_keep_R2: assert property (@(posedge clk) disable iff (rst)
    wr_mlo |=> ((dout_q[HALF_W-1:0] ^ $past(dout_q[HALF_W-1:0]))
                & $past(wdata[DATA_W-1:HALF_W])) == '0);
  assert_mlo_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_mlo |=> ((dout_q[HALF_W-1:0] ^ $past(wdata[HALF_W-1:0]))
                & ~$past(wdata[DATA_W-1:HALF_W])) == '0);
  // R3: high half obeys the same mask rule
  assert_mhi_keep_R3: assert property (@(posedge clk) disable iff (rst)
    wr_mhi |=> ((dout_q[PINS-1:HALF_W] ^ $past(dout_q[PINS-1:HALF_W]))
                & $past(wdata[HALF_W+HI_W-1:HALF_W])) == '0);
  // R7: set/clear semantics of the interrupt mask
  assert_ien_clear_R7: assert property (@(posedge clk) disable iff (rst)
    wr_ien |=> (imask_q & $past(wdata[PINS-1:0])) == '0);
  assert_idis_set_R7: assert property (@(posedge clk) disable iff (rst)
    wr_idis |=> (imask_q & $past(wdata[PINS-1:0])) == $past(wdata[PINS-1:0]));
  // R6: a driver is never enabled on a pin that was an input one cycle earlier
  assert_oe_dir_R6: assert property (@(posedge clk) disable iff (rst)
    (oe_q & ~$past(dir_q)) == '0);
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
  import gpio_mb_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 6,
  parameter int unsigned NARROW_BANKS = 3,
  parameter int unsigned NARROW_PINS  = 26,
  parameter int unsigned WIDE_PINS    = 32,
  parameter int unsigned TOTAL_PINS   = NARROW_BANKS * NARROW_PINS
                                      + (NUM_BANKS - NARROW_BANKS) * WIDE_PINS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [TOTAL_PINS-1:0] pin_in,
  output logic [TOTAL_PINS-1:0] pin_out,
  output logic [TOTAL_PINS-1:0] pin_oe
);
  logic [NUM_BANKS-1:0]             hit;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0]                rd_mux;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned P    = bank_pins(b, NARROW_BANKS, NARROW_PINS, WIDE_PINS);
    localparam int unsigned BASE = bank_base(b, NARROW_BANKS, NARROW_PINS, WIDE_PINS);
    gpio_mb_bank #(.BANK_IDX(b), .PINS(P)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (bus_wr),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .pin_in(pin_in[BASE +: P]),
      .rdata (bank_rd[b]),
      .hit   (hit[b]),
      .dout  (pin_out[BASE +: P]),
      .oe    (pin_oe[BASE +: P])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_mux = rd_mux | bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R8: unmapped offsets read zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !(|hit)) |=> bus_rdata == '0);
  // R9: read data holds without a strobe
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R8: at most one bank claims an address
  assert_single_hit_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: tb/gpio_multibank_bench.sv
`timescale 1ns/1ps
module gpio_multibank_bench;
  import gpio_mb_pkg::*;
  localparam int NB = 6, NN = 3, NP = 26, WP = 32, TP = 174;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [TP-1:0] pin_in = '0, pin_out, pin_oe;
  int n_chk = 0, n_bad = 0;
  logic [31:0] m_out[NB], m_dir[NB], m_oen[NB], m_imask[NB];

  always #2 clk = ~clk;

  gpio_multibank u_gpio_multibank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic int pins_of(int b); return (b < NN) ? NP : WP; endfunction
  function automatic int base_of(int b);
    return (b <= NN) ? b * NP : NN * NP + (b - NN) * WP;
  endfunction
  function automatic logic [31:0] pm(int b);
    return (pins_of(b) == 32) ? 32'hFFFF_FFFF : ((32'h1 << pins_of(b)) - 1);
  endfunction
  function automatic logic [31:0] slice_of(logic [TP-1:0] v, int b);
    logic [31:0] r = '0;
    for (int i = 0; i < pins_of(b); i++) r[i] = v[base_of(b) + i];
    return r;
  endfunction
  function automatic logic [ADDR_W-1:0] ctl(int b, int ofs);
    return ADDR_W'(32'h200 + 32'h40 * b + ofs);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic bwr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r, r0, r1, r2, pat, oldin;
    logic [15:0] mk, dt;
    logic [31:0] mpairs[5];
    mpairs[0] = 32'h0000_BEEF; mpairs[1] = 32'hFF00_1234; mpairs[2] = 32'h00FF_FFFF;
    mpairs[3] = 32'hFFFF_0000; mpairs[4] = 32'hAAAA_5555;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pin_out", {31'b0, |pin_out}, 32'h0);
    chk("R1 pin_oe", {31'b0, |pin_oe}, 32'h0);
    for (int b = 0; b < NB; b++) begin
      m_out[b] = '0; m_dir[b] = '0; m_oen[b] = '0; m_imask[b] = pm(b);
      brd(ADDR_W'(32'h40 + 4 * b), r); chk("R1 dout", r, 32'h0);
      brd(ctl(b, 4), r);  chk("R1 dir", r, 32'h0);
      brd(ctl(b, 8), r);  chk("R1 oen", r, 32'h0);
      brd(ctl(b, 12), r); chk("R1 imask", r, pm(b));
    end

    for (int b = 0; b < NB; b++) begin
      // R4 full replacement, R8 upper bits dropped
      for (int k = 0; k < 3; k++) begin
        pat = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? (32'h5A5A_C3C3 ^ b) : 32'h1357_9BDF;
        bwr(ADDR_W'(32'h40 + 4 * b), pat);
        m_out[b] = pat & pm(b);
        brd(ADDR_W'(32'h40 + 4 * b), r); chk("R4 R8 dout read", r, m_out[b]);
        chk("R4 pin_out", slice_of(pin_out, b), m_out[b]);
      end
      // R2 low masked writes
      for (int k = 0; k < 5; k++) begin
        mk = mpairs[k][31:16]; dt = mpairs[k][15:0];
        bwr(ADDR_W'(8 * b), mpairs[k]);
        m_out[b][15:0] = (m_out[b][15:0] & mk) | (dt & ~mk);
        brd(ADDR_W'(32'h40 + 4 * b), r); chk("R2 low masked", r, m_out[b]);
        chk("R2 pin_out", slice_of(pin_out, b), m_out[b]);
      end
      // R3 high masked writes
      for (int k = 0; k < 5; k++) begin
        mk = mpairs[k][31:16]; dt = mpairs[k][15:0] ^ 16'h0F0F;
        bwr(ADDR_W'(8 * b + 4), {mk, dt});
        m_out[b][31:16] = (m_out[b][31:16] & mk) | (dt & ~mk);
        m_out[b] = m_out[b] & pm(b);
        brd(ADDR_W'(32'h40 + 4 * b), r); chk("R3 high masked", r, m_out[b]);
        chk("R3 pin_out", slice_of(pin_out, b), m_out[b]);
      end
      // R8 write-only registers read zero
      brd(ADDR_W'(8 * b), r);     chk("R8 mask-write read", r, 32'h0);
      brd(ADDR_W'(8 * b + 4), r); chk("R8 mask-write read", r, 32'h0);
      // R6 direction and output enable
      m_dir[b] = (32'hF0F0_3C3C ^ (32'h1111 * b)) & pm(b);
      m_oen[b] = 32'hFF00_FF0F & pm(b);
      bwr(ctl(b, 4), 32'hF0F0_3C3C ^ (32'h1111 * b));
      bwr(ctl(b, 8), 32'hFF00_FF0F);
      @(negedge clk);
      chk("R6 pin_oe", slice_of(pin_oe, b), m_dir[b] & m_oen[b]);
      brd(ctl(b, 4), r); chk("R6 dir read", r, m_dir[b]);
      brd(ctl(b, 8), r); chk("R6 oen read", r, m_oen[b]);
      // R7 interrupt mask set/clear
      bwr(ctl(b, 16), 32'h0F0F_F00F); m_imask[b] = m_imask[b] & ~32'h0F0F_F00F;
      brd(ctl(b, 12), r); chk("R7 enable clears", r, m_imask[b]);
      bwr(ctl(b, 20), 32'h0303_0F01); m_imask[b] = (m_imask[b] | 32'h0303_0F01) & pm(b);
      brd(ctl(b, 12), r); chk("R7 disable sets", r, m_imask[b]);
      bwr(ctl(b, 16), 32'h0); bwr(ctl(b, 20), 32'h0); bwr(ctl(b, 12), 32'h0);
      brd(ctl(b, 12), r); chk("R7 zeros and mask write ignored", r, m_imask[b]);
      brd(ctl(b, 16), r); chk("R8 enable reg reads 0", r, 32'h0);
      // R5 input synchronizer latency
      oldin = slice_of(pin_in, b);
      pat = (32'hC0DE_A55A ^ (32'h0101_0101 * b)) & pm(b);
      @(negedge clk);
      for (int i = 0; i < pins_of(b); i++) pin_in[base_of(b) + i] = pat[i];
      bus_rd = 1'b1; bus_addr = ADDR_W'(32'h60 + 4 * b);
      @(negedge clk); r0 = bus_rdata;
      @(negedge clk); r1 = bus_rdata;
      @(negedge clk); r2 = bus_rdata;
      bus_rd = 1'b0;
      chk("R5 first edge old", r0, oldin);
      chk("R5 second edge old", r1, oldin);
      chk("R5 third edge new", r2, pat);
    end

    // R8 unmapped offsets
    brd(ADDR_W'(32'h40), r);
    brd(ADDR_W'(32'h030), r); chk("R8 unmapped 0x030", r, 32'h0);
    brd(ADDR_W'(32'h40), r);
    brd(ADDR_W'(32'h078), r); chk("R8 unmapped 0x078", r, 32'h0);
    brd(ADDR_W'(32'h40), r);
    brd(ADDR_W'(32'h218), r); chk("R8 unmapped 0x218", r, 32'h0);
    brd(ADDR_W'(32'h3FC), r); chk("R8 unmapped 0x3FC", r, 32'h0);
    bwr(ADDR_W'(32'h100), 32'hFFFF_FFFF);
    brd(ADDR_W'(32'h40), r); chk("R8 unmapped write harmless", r, m_out[0]);

    // R9 hold while idle
    brd(ADDR_W'(32'h40 + 4 * 3), r);
    bus_addr = ADDR_W'(32'h60);
    repeat (3) @(negedge clk);
    chk("R9 rdata hold", bus_rdata, m_out[3]);

    summary();
  end
endmodule